// File: doc/BRIEF.md
# Double-Edge Strobed Burst Receiver with Flow Pause

This block is the receiving end of a 16-bit burst link in which the sender moves one word per strobe transition, on the rising transition and on the falling one. The strobe and the data bus arrive from outside the local clock domain. Both pass through the same register chain, so they stay aligned. A change of the synchronised strobe captures the delayed data word into a local buffer. A consumer drains the buffer through a simple read port.

The receiver slows the sender with an active-low ready output. Driving it high asks the sender to stop, and driving it low lets the sender go on. A pause is raised when the free space in the buffer shrinks to two words plus a margin, or when the local logic asks for a hold. A pause is never raised before the current burst has delivered its first word. Because of the round trip, words can still arrive after a pause. The receiver notes whether the pause began close to the last strobe transition, inside the short window, or later. It allows one trailing word in the first case and two in the second. Any word beyond that allowance, or any word that meets a full buffer, sets a sticky overflow flag. The flag clears when the next burst starts.

Top module: `strobe_burst_rx`

## Requirements
- R1: Every transition of `strobe_in`, rising or falling, while `burst_active` is high stores exactly one word taken from `data_in`. Words leave the buffer in arrival order.
- R2: `ready_n` stays low while the current burst has not yet stored a word, even if `hold_req` is high.
- R3: Once a word has been stored in the burst, `ready_n` goes high when the free space (DEPTH minus stored words) is at most 2 plus MARGIN (3 with defaults, so at 5 stored words of 8).
- R4: `ready_n` returns low once the free space is above the threshold and `hold_req` is low.
- R5: `late_pause` reads 1 when the last pause began more than TSR_CYC clock cycles after the last detected strobe transition, and 0 when it began within that window.
- R6: While paused, `overflow` is set by the second trailing word after an in-window pause, and by the third after a late pause. It is also set by a word that arrives at a full buffer, and it then stays set.
- R7: A rising edge of `burst_active` clears `overflow`.
- R8: `rd_valid` is high exactly when the buffer holds a word. `rd_data` shows the oldest word, and `rd_en` with `rd_valid` removes it.
- R9: After reset `ready_n`, `rd_valid`, `overflow` and `late_pause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_active | input | 1 | High for the length of a burst |
| strobe_in | input | 1 | Sender strobe, asynchronous, both edges carry data |
| data_in | input | 16 | Sender data bus |
| hold_req | input | 1 | Local request to pause the sender |
| ready_n | output | 1 | Active-low ready; high means pause |
| rd_en | input | 1 | Remove the oldest word |
| rd_data | output | 16 | Oldest stored word |
| rd_valid | output | 1 | Buffer not empty |
| overflow | output | 1 | Sticky: too many trailing words, or a word that met a full buffer |
| late_pause | output | 1 | Last pause began outside the short window |

## Verification
A pause caused by buffer occupancy always starts one or two cycles after a strobe transition. From the ports it can therefore only give an in-window pause. To reach the late case, the bench stores a first word, waits well beyond TSR_CYC cycles with the strobe quiet, and only then raises `hold_req`. It then sends two trailing words, which must be accepted, and a third, which must set the overflow flag. The in-window case is set up the opposite way: `hold_req` is already high before the first word, so the pause follows that word at once and a second trailing word trips overflow.

// File: rtl/rx_pkg.sv
package rx_pkg;
    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  valid;
        word_t data;
    } cap_t;

    typedef enum logic {
        PST_RUN    = 1'b0,
        PST_PAUSED = 1'b1
    } pst_e;

    // trailing words tolerated after a pause
    function automatic logic [1:0] trail_bound(input logic in_window);
        return in_window ? 2'd1 : 2'd2;
    endfunction
endpackage

// File: rtl/rx_strobe_sync.sv
module rx_strobe_sync
    import rx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  strobe_in,
    input  word_t data_in,
    output cap_t  cap
);
    logic  s_chain [STAGES+1];
    word_t d_chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            s_chain[0] <= 1'b0;
            d_chain[0] <= '0;
        end else begin
            s_chain[0] <= strobe_in;
            d_chain[0] <= data_in;
        end
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                s_chain[i] <= 1'b0;
                d_chain[i] <= '0;
            end else begin
                s_chain[i] <= s_chain[i-1];
                d_chain[i] <= d_chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_chain[STAGES] <= 1'b0;
        else     s_chain[STAGES] <= s_chain[STAGES-1];
    end

    always_comb begin
        cap.valid = s_chain[STAGES-1] ^ s_chain[STAGES];
        cap.data  = d_chain[STAGES-1];
    end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import rx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  word_t         wdata,
    input  logic          pop,
    output word_t         rdata,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);
    word_t         mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH)); // R8
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!push && !pop) |=> $stable(level)); // R1
endmodule

// File: rtl/rx_pause_ctrl.sv
module rx_pause_ctrl
    import rx_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int MARGIN  = 1,
    parameter int TSR_CYC = 3,
    localparam int LW     = $clog2(DEPTH) + 1,
    localparam int THRESH = 2 + MARGIN,
    localparam int SW     = $clog2(TSR_CYC + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          burst_active,
    input  logic          strobe_edge,
    input  logic          push,
    input  logic          full,
    input  logic [LW-1:0] level,
    input  logic          hold_req,
    output logic          ready_n,
    output logic          overflow,
    output logic          late_pause
);
    pst_e          state_q;
    logic          burst_q, seen_q, in_window_q;
    logic [SW-1:0] since_q;
    logic [1:0]    extra_q;
    logic [LW-1:0] free;
    logic          want, burst_start;

    assign free        = LW'(DEPTH) - level;
    assign burst_start = burst_active && !burst_q;
    assign want        = burst_active && seen_q && ((free <= LW'(THRESH)) || hold_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_q     <= 1'b0;
            seen_q      <= 1'b0;
            since_q     <= SW'(TSR_CYC + 1);
            state_q     <= PST_RUN;
            in_window_q <= 1'b1;
            extra_q     <= '0;
            overflow    <= 1'b0;
        end else begin
            burst_q <= burst_active;

            if (!burst_active) seen_q <= 1'b0;
            else if (push)     seen_q <= 1'b1;

            if (strobe_edge)                        since_q <= '0;
            else if (since_q != SW'(TSR_CYC + 1))   since_q <= since_q + 1'b1;

            if (want && state_q == PST_RUN)
                in_window_q <= (since_q <= SW'(TSR_CYC));
            state_q <= want ? PST_PAUSED : PST_RUN;

            if (state_q == PST_RUN)            extra_q <= '0;
            else if (push && extra_q != 2'd3)  extra_q <= extra_q + 1'b1;

            if (burst_start)
                overflow <= 1'b0;
            else if (push && (full || (state_q == PST_PAUSED &&
                                       extra_q >= trail_bound(in_window_q))))
                overflow <= 1'b1;
        end
    end

    assign ready_n    = (state_q == PST_PAUSED);
    assign late_pause = !in_window_q;

    AST_NO_EARLY_PAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_n) |-> $past(seen_q)); // R2
    AST_FULL_PAUSE: assert property (@(posedge clk) disable iff (rst)
        (burst_active && seen_q && free <= LW'(THRESH)) |=> ready_n); // R3
    AST_RESUME: assert property (@(posedge clk) disable iff (rst)
        (!hold_req && free > LW'(THRESH)) |=> !ready_n); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overflow && !burst_start) |=> overflow); // R6
    AST_TRAIL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (ready_n && !overflow) |-> extra_q <= 2'd2); // R6
endmodule

// File: rtl/strobe_burst_rx.sv
module strobe_burst_rx
    import rx_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int MARGIN      = 1,
    parameter int TSR_CYC     = 3,
    parameter int SYNC_STAGES = 2,
    localparam int LW         = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        burst_active,
    input  logic        strobe_in,
    input  logic [15:0] data_in,
    input  logic        hold_req,
    output logic        ready_n,
    input  logic        rd_en,
    output logic [15:0] rd_data,
    output logic        rd_valid,
    output logic        overflow,
    output logic        late_pause
);
    cap_t          cap;
    logic          push, full, empty;
    logic [LW-1:0] level;

    rx_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .strobe_in(strobe_in), .data_in(data_in), .cap(cap)
    );

    assign push = cap.valid && burst_active;

    rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .wdata(cap.data), .pop(rd_en),
        .rdata(rd_data), .empty(empty), .full(full), .level(level)
    );

    rx_pause_ctrl #(.DEPTH(DEPTH), .MARGIN(MARGIN), .TSR_CYC(TSR_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .burst_active(burst_active), .strobe_edge(cap.valid),
        .push(push), .full(full), .level(level), .hold_req(hold_req),
        .ready_n(ready_n), .overflow(overflow), .late_pause(late_pause)
    );

    assign rd_valid = !empty;

    AST_VALID_DATA: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_en && !push) |=> (rd_valid && $stable(rd_data))); // R8
endmodule

// File: tb/sim_strobe_burst_rx.sv
module sim_strobe_burst_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        burst_active = 1'b0;
    logic        strobe_in = 1'b0;
    logic [15:0] data_in = '0;
    logic        hold_req = 1'b0;
    logic        rd_en = 1'b0;
    logic        ready_n, rd_valid, overflow, late_pause;
    logic [15:0] rd_data;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    logic [15:0] sent [$];

    always #5 clk = ~clk;

    strobe_burst_rx u0 (
        .clk(clk), .rst(rst), .burst_active(burst_active), .strobe_in(strobe_in),
        .data_in(data_in), .hold_req(hold_req), .ready_n(ready_n), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .overflow(overflow),
        .late_pause(late_pause)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        @(negedge clk);
        data_in   = w;
        strobe_in = ~strobe_in;
        sent.push_back(w);
        repeat (4) @(negedge clk);
    endtask

    task automatic pop_check(input string req);
        logic [15:0] e;
        @(negedge clk);
        e = sent.pop_front();
        check(rd_valid == 1'b1, req, rd_valid, 1);
        check(rd_data == e, req, rd_data, e);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic new_burst();
        @(negedge clk);
        burst_active = 1'b0;
        repeat (3) @(negedge clk);
        burst_active = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(ready_n == 0, "R9", ready_n, 0);
        check(rd_valid == 0, "R9", rd_valid, 0);
        check(overflow == 0, "R9", overflow, 0);
        check(late_pause == 0, "R9", late_pause, 0);

        // fill sweep over several data patterns
        for (int round = 0; round < 3; round++) begin
            new_burst();
            hold_req = 1'b0;
            check(overflow == 0, "R7", overflow, 0);
            for (int n = 1; n <= 5; n++) begin
                send_word(16'((round * 16'h3C5A) ^ (n * 16'h1111) ^ (n << round)));
                // R3: pause at 5 stored words (free 3)
                check(ready_n == (n >= 5), "R3", ready_n, (n >= 5));
                check(overflow == 0, "R6", overflow, 0);
            end
            check(late_pause == 0, "R5", late_pause, 0);
            pop_check("R1");
            check(ready_n == 0, "R4", ready_n, 0);
            for (int k = 0; k < 4; k++) pop_check("R1");
            check(rd_valid == 0, "R8", rd_valid, 0);
        end

        // in-window pause: hold before first word
        new_burst();
        hold_req = 1'b1;
        repeat (6) @(negedge clk);
        check(ready_n == 0, "R2", ready_n, 0);
        send_word(16'hA001);
        check(ready_n == 1, "R2", ready_n, 1);
        check(late_pause == 0, "R5", late_pause, 0);
        send_word(16'hA002);
        check(overflow == 0, "R6", overflow, 0);
        send_word(16'hA003);
        check(overflow == 1, "R6", overflow, 1);
        hold_req = 1'b0;
        repeat (2) @(negedge clk);
        check(ready_n == 0, "R4", ready_n, 0);
        check(overflow == 1, "R6", overflow, 1);
        for (int k = 0; k < 3; k++) pop_check("R1");

        // late pause
        new_burst();
        check(overflow == 0, "R7", overflow, 0);
        send_word(16'hB001);
        check(ready_n == 0, "R3", ready_n, 0);
        repeat (10) @(negedge clk);
        hold_req = 1'b1;
        repeat (2) @(negedge clk);
        check(ready_n == 1, "R5", ready_n, 1);
        check(late_pause == 1, "R5", late_pause, 1);
        send_word(16'hB002);
        send_word(16'hB003);
        check(overflow == 0, "R6", overflow, 0);
        send_word(16'hB004);
        check(overflow == 1, "R6", overflow, 1);
        hold_req = 1'b0;
        repeat (2) @(negedge clk);
        check(ready_n == 0, "R4", ready_n, 0);
        for (int k = 0; k < 4; k++) pop_check("R1");
        check(rd_valid == 0, "R8", rd_valid, 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule